// File: doc/BRIEF.md
# Interrupt Entry/Return Sequencer

This block decides when a small 8-bit controller core stops its instruction stream to service an interrupt, and it runs the stack traffic around that decision. At each accepted instruction boundary, or on a wake-up from sleep, it picks the pending request with the lowest index. It then pushes the two-byte return address onto a byte-wide stack and hands the core a vector fetch address. When the core retires a return-from-interrupt instruction, the block pops the two bytes back, presents the rebuilt address and turns the global enable on again. The core is stalled for every sequencing cycle.

The block owns the global interrupt-enable bit and applies the exact timing rules of the core. A disable instruction acts at once and beats a request that arrives in the same cycle. An enable instruction lets one more instruction run before any interrupt. Entry and return take four cycles each, and a wake-up from sleep adds four cycles in front of entry. Status flags other than the enable bit are left to software. The stack memory sits outside the block and is read combinationally through `stk_addr`/`stk_rdata`.

The control is a single state machine. `ST_IDLE` moves to `ST_PUSH_LO` on an accept at a boundary, to `ST_WAKE` on an accept from sleep, and to `ST_POP_HI` on a return. `ST_WAKE` holds for the wake-up count and then moves to `ST_PUSH_LO`. The entry chain runs `ST_PUSH_LO` → `ST_PUSH_HI` → `ST_ENT_WAIT` → `ST_VECTOR` → `ST_IDLE`. The return chain runs `ST_POP_HI` → `ST_POP_LO` → `ST_RET_WAIT` → `ST_RETURN` → `ST_IDLE`.

Top module: `irq_seq`

## Requirements
- R1: A boundary is a cycle with `insn_done`=1 and `multi_busy`=0 and no `op_cli`, `op_sei` or `op_reti`. A boundary in `ST_IDLE` with `gie`=1 and any `irq_req` bit set is accepted at that clock edge. `core_stall` is then 1 for exactly the four following cycles. In the fourth of those cycles `vec_valid`=1.
- R2: In the first entry cycle the block writes the low byte of `pc_next` (sampled at the accepting edge) to address `sp`. In the second entry cycle it writes the high byte to address `sp`-1. `sp` drops by one after each write.
- R3: The serviced index k is the lowest set bit of `irq_req`, and `vec_addr` = 2*k.
- R4: `op_reti` with `insn_done`=1 and `multi_busy`=0 starts a return. `core_stall` is 1 for the next four cycles, with reads at `sp`+1 in the first cycle and `sp`+2 in the second. The fourth cycle gives `ret_valid`=1 with `ret_pc` = {first byte read, second byte read}. `sp` ends 2 higher, and `gie` is 1 from the cycle after.
- R5: No interrupt is accepted while `multi_busy`=1, even when `insn_done`=1.
- R6: A boundary carrying `op_cli` is never accepted, even with a request present in that cycle, and `gie` is 0 from the next cycle.
- R7: A boundary carrying `op_sei` is never accepted. `gie` is 1 from the next cycle, so the earliest accept is at the boundary after the next instruction.
- R8: With `sleeping`=1, `wake_ready`=1, `gie`=1 and a request, entry is accepted without a boundary. `core_stall` is then 1 for eight cycles: four wake cycles, then the R2 writes, with `vec_valid` in the eighth cycle. With `wake_ready`=0 nothing is accepted.
- R9: `gie` is 0 from the first entry cycle on and stays 0 until a return or an enable instruction, so requests are not taken inside a handler.
- R10: While `rst_n`=0 and after its release: `gie`=0, `sp` = `SP_RST`, `core_stall`=0, and no stack strobe or valid is asserted.
- R11: While `gie`=0, requests at boundaries cause no entry and `core_stall` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_IRQ | Pending, enabled requests; bit k is vector index k |
| insn_done | input | 1 | An instruction completes in this cycle |
| multi_busy | input | 1 | A multi-cycle instruction is still executing |
| op_sei | input | 1 | Completing instruction is enable-interrupts |
| op_cli | input | 1 | Completing instruction is disable-interrupts |
| op_reti | input | 1 | Completing instruction is return-from-interrupt |
| sleeping | input | 1 | Core is in sleep mode |
| wake_ready | input | 1 | Wake-up start-up delay has finished |
| pc_next | input | 16 | Return address to save on entry |
| stk_rdata | input | 8 | Stack byte at `stk_addr` (combinational read) |
| gie | output | 1 | Global interrupt-enable bit |
| core_stall | output | 1 | Core must hold while a sequence runs |
| stk_we | output | 1 | Stack byte write strobe |
| stk_re | output | 1 | Stack byte read strobe |
| stk_addr | output | SP_W | Stack byte address |
| stk_wdata | output | 8 | Stack write byte |
| sp | output | SP_W | Stack pointer |
| vec_valid | output | 1 | Vector fetch address is valid |
| vec_addr | output | 16 | Vector fetch address |
| ret_valid | output | 1 | Restored return address is valid |
| ret_pc | output | 16 | Restored return address |

## Verification
A wrong state register shows up within one cycle as a `core_stall` or stack strobe at the wrong time. The bench model predicts every strobe and address for every cycle, so the slip is caught at once. A wrong byte order or address slope stays hidden during entry only when both the write data and the addresses are off in a matching way. Even then, the pair of popped bytes disagrees in the `ret_pc` of the following return, four cycles after that return starts. A stale or early enable bit is seen on the `gie` port in the very next cycle. It is also seen as an entry that starts one boundary too early or too late.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int PC_W   = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAKE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_ENT_WAIT,
        ST_VECTOR,
        ST_POP_HI,
        ST_POP_LO,
        ST_RET_WAIT,
        ST_RETURN
    } seq_state_t;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N_IRQ = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_IRQ-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // lowest index wins: scan downwards so the last hit is the smallest
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_sp_unit.sv
module irq_sp_unit #(
    parameter int          SP_W   = 16,
    parameter int unsigned SP_RST = 'h04FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec,
    input  logic            inc,
    output logic [SP_W-1:0] sp
);

    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= SP_W'(SP_RST);
        else if (dec) sp <= sp - SP_W'(1);
        else if (inc) sp <= sp + SP_W'(1);
    end

    // R2/R4: one byte moves per cycle, never both directions at once
    assert_sp_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec && inc))
        else $error("stack pointer asked to move both ways");

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int          N_IRQ    = 8,
    parameter int          SP_W     = 16,
    parameter int unsigned SP_RST   = 'h04FF,
    parameter int          WAKE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             insn_done,
    input  logic             multi_busy,
    input  logic             op_sei,
    input  logic             op_cli,
    input  logic             op_reti,
    input  logic             sleeping,
    input  logic             wake_ready,
    input  logic [15:0]      pc_next,
    input  logic [7:0]       stk_rdata,
    output logic             gie,
    output logic             core_stall,
    output logic             stk_we,
    output logic             stk_re,
    output logic [SP_W-1:0]  stk_addr,
    output logic [7:0]       stk_wdata,
    output logic [SP_W-1:0]  sp,
    output logic             vec_valid,
    output logic [15:0]      vec_addr,
    output logic             ret_valid,
    output logic [15:0]      ret_pc
);

    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
    localparam int CNT_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

    seq_state_t          state, state_n;
    logic                gie_q;
    logic [IDX_W-1:0]    pick_idx, idx_q;
    logic                pick_any;
    logic [PC_W-1:0]     pc_q;
    logic [CNT_W-1:0]    wcnt;
    logic [BYTE_W-1:0]   hi_q, lo_q;
    logic                sp_dec, sp_inc;

    logic idle, bnd, take_bnd, take_wake, accept, start_ret;

    irq_pick #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_pick (
        .req (irq_req),
        .any (pick_any),
        .idx (pick_idx)
    );

    irq_sp_unit #(.SP_W(SP_W), .SP_RST(SP_RST)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (sp_dec),
        .inc   (sp_inc),
        .sp    (sp)
    );

    assign idle      = (state == ST_IDLE);
    assign bnd       = insn_done & ~multi_busy;
    assign take_bnd  = bnd & ~op_cli & ~op_sei & ~op_reti;
    assign take_wake = sleeping & wake_ready;
    assign accept    = idle & gie_q & pick_any & (take_bnd | take_wake);
    assign start_ret = idle & bnd & op_reti;

    // next-state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (accept)         state_n = take_bnd ? ST_PUSH_LO : ST_WAKE;
                else if (start_ret) state_n = ST_POP_HI;
            end
            ST_WAKE:     if (wcnt == CNT_W'(WAKE_CYC - 1)) state_n = ST_PUSH_LO;
            ST_PUSH_LO:  state_n = ST_PUSH_HI;
            ST_PUSH_HI:  state_n = ST_ENT_WAIT;
            ST_ENT_WAIT: state_n = ST_VECTOR;
            ST_VECTOR:   state_n = ST_IDLE;
            ST_POP_HI:   state_n = ST_POP_LO;
            ST_POP_LO:   state_n = ST_RET_WAIT;
            ST_RET_WAIT: state_n = ST_RETURN;
            ST_RETURN:   state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // sequencing data: enable bit, captured vector, return address, counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            idx_q <= '0;
            pc_q  <= '0;
            wcnt  <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            if (accept)                          gie_q <= 1'b0;
            else if (state == ST_RETURN)         gie_q <= 1'b1;
            else if (idle && bnd && op_cli)      gie_q <= 1'b0;
            else if (idle && bnd && op_sei)      gie_q <= 1'b1;

            if (accept) begin
                idx_q <= pick_idx;
                pc_q  <= pc_next;
                wcnt  <= '0;
            end else if (state == ST_WAKE) begin
                wcnt  <= wcnt + CNT_W'(1);
            end

            if (state == ST_POP_HI) hi_q <= stk_rdata;
            if (state == ST_POP_LO) lo_q <= stk_rdata;
        end
    end

    // outputs
    always_comb begin
        stk_we    = 1'b0;
        stk_re    = 1'b0;
        stk_addr  = sp;
        stk_wdata = '0;
        vec_valid = 1'b0;
        ret_valid = 1'b0;
        sp_dec    = 1'b0;
        sp_inc    = 1'b0;
        unique case (state)
            ST_PUSH_LO: begin
                stk_we    = 1'b1;
                stk_wdata = pc_q[7:0];
                sp_dec    = 1'b1;
            end
            ST_PUSH_HI: begin
                stk_we    = 1'b1;
                stk_wdata = pc_q[15:8];
                sp_dec    = 1'b1;
            end
            ST_VECTOR:  vec_valid = 1'b1;
            ST_POP_HI, ST_POP_LO: begin
                stk_re   = 1'b1;
                stk_addr = sp + SP_W'(1);
                sp_inc   = 1'b1;
            end
            ST_RETURN:  ret_valid = 1'b1;
            default: ;
        endcase
    end

    assign gie        = gie_q;
    assign core_stall = ~idle;
    assign vec_addr   = {{(PC_W - IDX_W - 1){1'b0}}, idx_q, 1'b0};
    assign ret_pc     = {hi_q, lo_q};

    // R1: the vector appears three cycles after the first push
    assert_entry_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($past(stk_we, 3) && $past(core_stall, 3)))
        else $error("vector not four cycles into entry");

    // R2: second push lands one byte below the first
    assert_push_slope_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_HI) |-> ($past(stk_we) && stk_addr == $past(stk_addr) - SP_W'(1)))
        else $error("push addresses not descending");

    // R2: each write leaves the pointer one lower
    assert_sp_after_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |=> (sp == $past(sp) - SP_W'(1)))
        else $error("stack pointer not decremented by a push");

    // R4: return completion re-enables interrupts
    assert_return_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> gie)
        else $error("enable bit not set after return");

    // R5: a busy multi-cycle instruction is never interrupted
    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && multi_busy && !sleeping) |=> !core_stall)
        else $error("entry started during multi-cycle instruction");

    // R6: disable wins a same-cycle race
    assert_disable_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && insn_done && op_cli && !sleeping) |=> (!core_stall && !gie))
        else $error("entry taken on a disable boundary");

    // R7: the enable instruction's own boundary never enters
    assert_enable_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && insn_done && op_sei && !sleeping) |=> !core_stall)
        else $error("entry taken right after enable");

    // R9: enable bit is low when the vector is handed out
    assert_entry_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !gie)
        else $error("enable bit still set at vector");

endmodule

// File: tb/irq_seq_bench.sv
module irq_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_IRQ      = 8;
    localparam int SP_W       = 16;
    localparam int SP_RST     = 'h04FF;
    localparam int WDOG       = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_IRQ-1:0] irq_req = '0;
    logic insn_done = 0, multi_busy = 0, op_sei = 0, op_cli = 0, op_reti = 0;
    logic sleeping = 0, wake_ready = 0;
    logic [15:0] pc_next = '0;
    logic [7:0]  stk_rdata;
    logic gie, core_stall, stk_we, stk_re, vec_valid, ret_valid;
    logic [SP_W-1:0] stk_addr, sp;
    logic [7:0]  stk_wdata;
    logic [15:0] vec_addr, ret_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_seq #(.N_IRQ(N_IRQ), .SP_W(SP_W), .SP_RST(SP_RST), .WAKE_CYC(4)) u_irq_seq (
        .clk, .rst_n, .irq_req, .insn_done, .multi_busy, .op_sei, .op_cli, .op_reti,
        .sleeping, .wake_ready, .pc_next, .stk_rdata, .gie, .core_stall, .stk_we,
        .stk_re, .stk_addr, .stk_wdata, .sp, .vec_valid, .vec_addr, .ret_valid, .ret_pc
    );

    // external stack memory, combinational read
    logic [7:0] stk_mem [0:255];
    initial for (int i = 0; i < 256; i++) stk_mem[i] = 8'h00;
    always @(posedge clk) if (stk_we) stk_mem[stk_addr[7:0]] <= stk_wdata;
    assign stk_rdata = stk_mem[stk_addr[7:0]];

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct {
        bit stall, we, re, vec, ret, gie;
        int addr, wdata, sp, vaddr, rpc;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    bit   r_gie, pend_gie, in_seq;
    int   r_sp;
    int   ref_mem [256];

    function automatic exp_t blank(input bit g, input int s);
        exp_t e;
        e.stall = 0; e.we = 0; e.re = 0; e.vec = 0; e.ret = 0; e.gie = g;
        e.addr = 0; e.wdata = 0; e.sp = s; e.vaddr = 0; e.rpc = 0;
        return e;
    endfunction

    always @(posedge clk) begin
        exp_t e;
        bit bnd, plain, wake;
        int k;
        if (!rst_n) begin
            q.delete();
            r_gie = 0; pend_gie = 0; in_seq = 0; r_sp = SP_RST;
            cur = blank(0, SP_RST);
        end else if (q.size() != 0) begin
            cur = q.pop_front();
        end else if (in_seq) begin
            in_seq = 0;
            if (pend_gie) begin r_gie = 1; pend_gie = 0; end
            cur = blank(r_gie, r_sp);
        end else begin
            bnd   = insn_done && !multi_busy;
            plain = bnd && !op_cli && !op_sei && !op_reti;
            wake  = sleeping && wake_ready;
            if (r_gie && (irq_req != 0) && (plain || wake)) begin
                k = 0;
                for (int i = N_IRQ - 1; i >= 0; i--) if (irq_req[i]) k = i;
                r_gie = 0;
                if (!plain) repeat (4) begin
                    e = blank(0, r_sp); e.stall = 1; q.push_back(e);
                end
                e = blank(0, r_sp); e.stall = 1; e.we = 1; e.addr = r_sp;
                e.wdata = pc_next[7:0]; q.push_back(e);
                ref_mem[r_sp & 255] = pc_next[7:0];
                r_sp = (r_sp - 1) & 16'hFFFF;
                e = blank(0, r_sp); e.stall = 1; e.we = 1; e.addr = r_sp;
                e.wdata = pc_next[15:8]; q.push_back(e);
                ref_mem[r_sp & 255] = pc_next[15:8];
                r_sp = (r_sp - 1) & 16'hFFFF;
                e = blank(0, r_sp); e.stall = 1; q.push_back(e);
                e = blank(0, r_sp); e.stall = 1; e.vec = 1; e.vaddr = 2 * k; q.push_back(e);
                cur = q.pop_front(); in_seq = 1;
            end else if (bnd && op_reti) begin
                e = blank(r_gie, r_sp); e.stall = 1; e.re = 1; e.addr = (r_sp + 1) & 16'hFFFF;
                q.push_back(e);
                e = blank(r_gie, (r_sp + 1) & 16'hFFFF); e.stall = 1; e.re = 1;
                e.addr = (r_sp + 2) & 16'hFFFF; q.push_back(e);
                e = blank(r_gie, (r_sp + 2) & 16'hFFFF); e.stall = 1; q.push_back(e);
                e = blank(r_gie, (r_sp + 2) & 16'hFFFF); e.stall = 1; e.ret = 1;
                e.rpc = (ref_mem[(r_sp + 1) & 255] << 8) | ref_mem[(r_sp + 2) & 255];
                q.push_back(e);
                r_sp = (r_sp + 2) & 16'hFFFF; pend_gie = 1;
                cur = q.pop_front(); in_seq = 1;
            end else begin
                if (bnd && op_cli)      r_gie = 0;
                else if (bnd && op_sei) r_gie = 1;
                cur = blank(r_gie, r_sp);
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R1 core_stall", core_stall, cur.stall);
            cmp("R9 gie", gie, cur.gie);
            cmp("R2 sp", sp, cur.sp);
            cmp("R2 stk_we", stk_we, cur.we);
            cmp("R4 stk_re", stk_re, cur.re);
            cmp("R1 vec_valid", vec_valid, cur.vec);
            cmp("R4 ret_valid", ret_valid, cur.ret);
            if (cur.we) begin
                cmp("R2 push addr", stk_addr, cur.addr);
                cmp("R2 push data", stk_wdata, cur.wdata);
            end
            if (cur.re)  cmp("R4 pop addr", stk_addr, cur.addr);
            if (cur.vec) cmp("R3 vec_addr", vec_addr, cur.vaddr);
            if (cur.ret) cmp("R4 ret_pc", ret_pc, cur.rpc);
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            errors++;
            $display("FAIL R1 watchdog: cycles=%0d expected<=%0d", cyc, WDOG);
            summary();
        end
    end

    // ---------------- stimulus ----------------
    task automatic boundary(input bit s, input bit c, input bit r);
        insn_done = 1; op_sei = s; op_cli = c; op_reti = r;
        @(negedge clk);
        insn_done = 0; op_sei = 0; op_cli = 0; op_reti = 0;
    endtask

    task automatic count_stall(output int n);
        n = 0;
        while (core_stall) begin n++; @(negedge clk); end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        cmp("R10 gie in reset", gie, 0);
        cmp("R10 sp in reset", sp, SP_RST);
        cmp("R10 stall in reset", core_stall, 0);
        cmp("R10 strobes in reset", {stk_we, stk_re, vec_valid, ret_valid}, 0);
        rst_n = 1;
        @(negedge clk);

        // R11: requests ignored while disabled
        irq_req = 8'h04;
        repeat (3) begin boundary(0, 0, 0); cmp("R11 no entry while disabled", core_stall, 0); end

        // R7: enable boundary does not enter; next boundary does
        irq_req = 8'h28; pc_next = 16'h1234;
        boundary(1, 0, 0);
        cmp("R7 no entry on enable boundary", core_stall, 0);
        cmp("R7 enable visible next cycle", gie, 1);
        boundary(0, 0, 0);
        count_stall(n);
        cmp("R1 entry stall cycles", n, 4);

        // R9: handler boundaries do not re-enter
        pc_next = 16'h2000;
        repeat (2) begin boundary(0, 0, 0); cmp("R9 no nested entry", core_stall, 0); end
        cmp("R9 enable still clear", gie, 0);

        // nested entry after explicit enable in handler
        boundary(1, 0, 0);
        pc_next = 16'hABCD;
        boundary(0, 0, 0);
        count_stall(n);
        cmp("R1 nested entry stall cycles", n, 4);
        irq_req = '0;
        boundary(0, 0, 1);
        count_stall(n);
        cmp("R4 return stall cycles", n, 4);
        cmp("R4 enable after return", gie, 1);
        boundary(0, 1, 0);
        boundary(0, 0, 1);
        count_stall(n);
        cmp("R4 sp restored", sp, SP_RST);

        // R5: busy multi-cycle instruction holds off entry
        irq_req = 8'h80; pc_next = 16'h0F0E;
        insn_done = 1; multi_busy = 1;
        repeat (3) begin @(negedge clk); cmp("R5 no entry while busy", core_stall, 0); end
        multi_busy = 0;
        @(negedge clk);
        insn_done = 0;
        count_stall(n);
        cmp("R5 entry once instruction completes", n, 4);
        irq_req = '0;
        boundary(0, 0, 1);
        count_stall(n);

        // R6: disable beats a same-cycle request
        irq_req = 8'h01;
        boundary(0, 1, 0);
        cmp("R6 no entry on disable boundary", core_stall, 0);
        cmp("R6 enable cleared", gie, 0);
        boundary(0, 0, 0);
        cmp("R6 still no entry", core_stall, 0);

        // R8: wake from sleep adds four cycles
        irq_req = '0;
        boundary(1, 0, 0);
        sleeping = 1; irq_req = 8'h10; pc_next = 16'h5A5A;
        repeat (3) begin @(negedge clk); cmp("R8 no entry before wake_ready", core_stall, 0); end
        wake_ready = 1;
        @(negedge clk);
        sleeping = 0; wake_ready = 0;
        count_stall(n);
        cmp("R8 wake entry stall cycles", n, 8);
        irq_req = '0;
        boundary(0, 0, 1);
        count_stall(n);

        // R3/R7: lowest vector, enable already set still defers one instruction
        irq_req = 8'h01; pc_next = 16'h0102;
        boundary(1, 0, 0);
        cmp("R7 enable boundary defers entry", core_stall, 0);
        boundary(0, 0, 0);
        count_stall(n);
        cmp("R3 entry for index 0", n, 4);
        irq_req = '0;
        boundary(0, 0, 1);
        count_stall(n);
        cmp("R4 final sp", sp, SP_RST);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule